// File: doc/BRIEF.md
# System-Management RAM Access Control Register

This block is an 8-bit control register that decides whether the protected system-management RAM range is visible to processor memory accesses. Configuration software writes it through a simple write port, and its full value can be read back at any time. A global enable bit gates all of its controls. An open control exposes the range outside management mode. A close control hides the range from data accesses while in management mode, but code fetches still see it. A lock control freezes the security-relevant fields until reset.

The memory decoder uses the `dram_visible` output to route accesses to the protected range. The block applies the lock sequence: open must already be clear when lock is written. It also defines the result of the illegal open-plus-close write and reports that write on a sticky flag.

Top module: `smram_ctl`

## Requirements
- R1: After reset, `rd_data` is 0x02, `dram_visible` is 0 and `sw_conflict` is 0.
- R2: `rd_data` bit 6 is open, bit 5 is close, bit 4 is lock and bit 3 is the global enable. Bit 7 always reads 0 and bits 2:0 always read 010b, whatever value is written. An accepted write shows on `rd_data` in the cycle after the clock edge that takes it.
- R3: While the global enable bit is 0, `dram_visible` is 0.
- R4: With the global enable set and `smm_active` low, `dram_visible` is 1 exactly when open is 1 and lock is 0.
- R5: With the global enable set and `smm_active` high, `dram_visible` is 1 unless close is 1 and `code_fetch` is 0.
- R6: An unlocked write with bits 6 and 5 both 1 stores close=1 and open=0, and it sets `sw_conflict`. `sw_conflict` stays 1 until reset.
- R7: The lock bit of a write is accepted only when the stored open is 0 and bit 3 of the same write is 1. Otherwise lock stays 0 and the other fields of the write still apply.
- R8: A write whose lock bit is accepted also stores open=0, whatever bit 6 of that write holds.
- R9: Once lock is 1, writes leave open, lock and the global enable unchanged, while close follows bit 5 of each write. Only reset clears lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| smm_active | input | 1 | Processor is in system-management mode |
| code_fetch | input | 1 | Current access is an instruction fetch |
| rd_data | output | 8 | Register readback |
| dram_visible | output | 1 | Protected range is routed to memory |
| sw_conflict | output | 1 | Sticky flag: open and close were written together |

## Verification
The assertions take `smm_active` and `code_fetch` to be the attributes of the access being decoded in that cycle. They treat `dram_visible` as a purely combinational view of the current state and these inputs. They also take each write to be a single-cycle strobe whose effect is judged at the next edge. The stimulus changes inputs only on the falling edge and holds them across each rising edge. It checks visibility in the cycle after the write has settled.

// File: rtl/smram_ctl_pkg.sv
package smram_ctl_pkg;
  localparam int REG_W     = 8;
  localparam int SEG_W     = 3;
  localparam int BIT_OPEN  = 6;
  localparam int BIT_CLOSE = 5;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_GEN   = 3;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic gen;
  } smram_fields_t;

  // lock may be taken only with gen in the same write and open already clear
  function automatic logic lock_ok(smram_fields_t cur, logic [REG_W-1:0] wd);
    return !cur.lock && wd[BIT_LOCK] && wd[BIT_GEN] && !cur.open;
  endfunction

  function automatic logic conflict_hit(smram_fields_t cur, logic [REG_W-1:0] wd);
    return !cur.lock && wd[BIT_OPEN] && wd[BIT_CLOSE];
  endfunction

  function automatic smram_fields_t next_fields(smram_fields_t cur, logic [REG_W-1:0] wd);
    smram_fields_t nf;
    nf       = cur;
    nf.close = wd[BIT_CLOSE];
    if (!cur.lock) begin
      nf.gen  = wd[BIT_GEN];
      nf.open = wd[BIT_OPEN] && !wd[BIT_CLOSE];
      if (lock_ok(cur, wd)) begin
        nf.lock = 1'b1;
        nf.open = 1'b0;
      end
    end
    return nf;
  endfunction

  function automatic logic visible(smram_fields_t f, logic smm, logic fetch);
    if (!f.gen) return 1'b0;
    if (smm)    return !(f.close && !fetch);
    return f.open && !f.lock;
  endfunction

  function automatic logic [REG_W-1:0] pack_rd(smram_fields_t f, logic [SEG_W-1:0] seg);
    return {1'b0, f.open, f.close, f.lock, f.gen, seg};
  endfunction
endpackage

// File: rtl/smram_field_regs.sv
module smram_field_regs
  import smram_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output smram_fields_t    fields_q,
  output logic             conflict_q,
  output logic             lock_accept
);
  logic conflict_now;

  assign lock_accept  = wr_en && lock_ok(fields_q, wr_data);
  assign conflict_now = wr_en && conflict_hit(fields_q, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q   <= '0;
      conflict_q <= 1'b0;
    end else begin
      if (wr_en)        fields_q   <= next_fields(fields_q, wr_data);
      if (conflict_now) conflict_q <= 1'b1;
    end
  end
endmodule

// File: rtl/smram_visibility.sv
module smram_visibility
  import smram_ctl_pkg::*;
(
  input  smram_fields_t fields,
  input  logic          smm_active,
  input  logic          code_fetch,
  output logic          vis
);
  always_comb vis = visible(fields, smm_active, code_fetch);
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_ctl_pkg::*;
#(
  parameter logic [SEG_W-1:0] SEG_CODE = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             smm_active,
  input  logic             code_fetch,
  output logic [REG_W-1:0] rd_data,
  output logic             dram_visible,
  output logic             sw_conflict
);
  smram_fields_t fields_q;
  logic          lock_accept;

  smram_field_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .fields_q   (fields_q),
    .conflict_q (sw_conflict),
    .lock_accept(lock_accept)
  );

  smram_visibility u_vis (
    .fields    (fields_q),
    .smm_active(smm_active),
    .code_fetch(code_fetch),
    .vis       (dram_visible)
  );

  assign rd_data = pack_rd(fields_q, SEG_CODE);
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       smm_active,
  input logic       code_fetch,
  input logic [7:0] rd_data,
  input logic       dram_visible,
  input logic       sw_conflict,
  input logic       lock_accept
);
  assert_gen_off_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |-> !dram_visible);

  assert_open_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && !smm_active && rd_data[6] && !rd_data[4]) |-> dram_visible);

  assert_close_data_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_active && rd_data[5] && !code_fetch) |-> !dram_visible);

  assert_conflict_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_conflict |=> sw_conflict);

  assert_conflict_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[4] && wr_data[6] && wr_data[5]) |=> (!rd_data[6] && rd_data[5] && sw_conflict));

  assert_lock_needs_closed_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[4] && rd_data[6]) |=> !rd_data[4]);

  assert_lock_clears_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_accept |=> (rd_data[4] && !rd_data[6]));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |=> (rd_data[4] && $stable(rd_data[3]) && !rd_data[6]));
endmodule

bind smram_ctl smram_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .smm_active  (smm_active),
  .code_fetch  (code_fetch),
  .rd_data     (rd_data),
  .dram_visible(dram_visible),
  .sw_conflict (sw_conflict),
  .lock_accept (lock_accept)
);

// File: tb/smram_ctl_bench.sv
module smram_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       smm_active = 1'b0;
  logic       code_fetch = 1'b0;
  logic [7:0] rd_data;
  logic       dram_visible;
  logic       sw_conflict;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smram_ctl u_smram_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .smm_active(smm_active), .code_fetch(code_fetch),
    .rd_data(rd_data), .dram_visible(dram_visible), .sw_conflict(sw_conflict)
  );

  // {wdata, smm, fetch, exp_rd, exp_vis, exp_err}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {8'h48, 1'b0, 1'b0, 8'h4A, 1'b1, 1'b0},  // R4 open visible
    {8'h40, 1'b0, 1'b0, 8'h42, 1'b0, 1'b0},  // R3 gen off
    {8'h28, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b0},  // R5 close hides data
    {8'h28, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b0},  // R5 fetch still visible
    {8'h08, 1'b1, 1'b0, 8'h0A, 1'b1, 1'b0},  // R5 smm, no close
    {8'h8F, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b0},  // R2 fixed bits
    {8'h68, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b1},  // R6 conflict
    {8'h48, 1'b0, 1'b0, 8'h4A, 1'b1, 1'b1},  // R6 sticky
    {8'h58, 1'b0, 1'b0, 8'h4A, 1'b1, 1'b1},  // R7 lock refused, open set
    {8'h18, 1'b0, 1'b0, 8'h0A, 1'b0, 1'b1},  // R7 refused, open cleared
    {8'h18, 1'b0, 1'b0, 8'h1A, 1'b0, 1'b1},  // R7 accepted
    {8'h48, 1'b1, 1'b0, 8'h1A, 1'b1, 1'b1},  // R9 open ignored
    {8'h20, 1'b1, 1'b0, 8'h3A, 1'b0, 1'b1},  // R9 close writable, gen kept
    {8'h00, 1'b0, 1'b0, 8'h1A, 1'b0, 1'b1}   // R9 lock kept, R4 locked
  };

  task automatic check(string req, logic [7:0] rd_exp, logic vis_exp, logic err_exp);
    checks++;
    if (rd_data !== rd_exp || dram_visible !== vis_exp || sw_conflict !== err_exp) begin
      errors++;
      $display("FAIL %s: rd=%h vis=%b err=%b expected rd=%h vis=%b err=%b",
               req, rd_data, dram_visible, sw_conflict, rd_exp, vis_exp, err_exp);
    end
  endtask

  task automatic do_write(logic [7:0] d, logic smm, logic fetch);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; smm_active = smm; code_fetch = fetch;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    smm_active = 1'b0; code_fetch = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 8'h02, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][19:12], VEC[i][11], VEC[i][10]);
      check($sformatf("R2 vector %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    do_reset();
    check("R1 R9 reset clears lock and flag", 8'h02, 1'b0, 1'b0);

    do_write(8'h10, 1'b0, 1'b0);
    check("R7 lock without gen", 8'h02, 1'b0, 1'b0);

    do_write(8'h58, 1'b0, 1'b0);
    check("R8 lock forces open clear", 8'h1A, 1'b0, 1'b0);

    do_write(8'h40, 1'b0, 1'b0);
    check("R9 gen and open frozen", 8'h1A, 1'b0, 1'b0);

    do_write(8'h68, 1'b1, 1'b0);
    check("R9 R6 no conflict when locked", 8'h3A, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule